// File: doc/BRIEF.md
# Segment Selector Load Unit

This block loads 16-bit selectors into the seven selector-holding registers of a segmented address path: six segment registers and the local descriptor-table register. A software-written pair of table base registers (one global, one local) supplies the base address. On an accepted load that is not null, the unit computes the byte address of the descriptor entry. It issues exactly one descriptor-fetch request over a valid/ready handshake and waits for the response. It then writes the selector and the returned descriptor into the target register together. The descriptor lands in a hidden cache attached to that register.

Null selectors never go to memory. Where a null load is legal, the target is marked unusable. Where it is illegal, the unit raises a one-cycle general-protection fault and reports the faulting selector. Execution logic reports each reference through a segment register on a use port. A reference through an unusable register faults unless the 64-bit-mode flag is set. A read port brings out the selector, hidden descriptor and unusable bit of any register.

The controller has three states. `ST_IDLE` accepts loads. `ST_ISSUE` holds the fetch request until it is taken. `ST_AWAIT` waits for the descriptor response.
- `ST_IDLE -> ST_ISSUE`: a non-null load is accepted.
- `ST_ISSUE -> ST_AWAIT`: the fetch is taken while `fetch_valid` and `fetch_ready` are both high.
- `ST_AWAIT -> ST_IDLE`: `resp_valid` arrives and the register is written.
- A null load, legal or faulting, leaves the controller in `ST_IDLE`.

Top module: `seg_load_unit`

## Requirements
- R1: The selector fields are: bits 15..3 are the entry index, bit 2 chooses the table (0 global, 1 local), and bits 1..0 are the requested privilege. The fetch address is the chosen table base plus the index times 8.
- R2: A non-null load raises `fetch_valid` in the cycle after acceptance. It holds `fetch_valid` and `fetch_addr` steady until `fetch_ready` is seen. Exactly one fetch request is made per load.
- R3: `ld_ready` is low from the cycle after a non-null load is accepted until the cycle after `resp_valid` is taken. A load presented while `ld_ready` is low is ignored.
- R4: When the response is taken, the target register shows the loaded selector, the returned descriptor and a cleared unusable bit. Target codes are CS=0, DS=1, ES=2, FS=3, GS=4, SS=5 and LDTR=6.
- R5: A selector whose index is 0 and whose table bit is 0 is null, whatever its privilege bits. A null load into DS, ES, FS, GS or LDTR issues no fetch and keeps `ld_ready` high. It writes the selector, sets the unusable bit and clears the hidden descriptor.
- R6: A null load into CS or SS issues no fetch. It pulses `gp_fault` for one cycle, starting in the cycle after acceptance, with `gp_selector` equal to the faulting selector. The target register is left unchanged.
- R7: A use of a register whose unusable bit is set raises `gp_fault` in the next cycle, with that register's selector, when `mode64` is 0. With `mode64` at 1, or for a usable register, no fault is raised.
- R8: After reset every register holds selector 0, a set unusable bit and a zero descriptor. `ld_ready` is high, and `fetch_valid` and `gp_fault` are low.
- R9: A table-base write (`tbl_local` 0 for global, 1 for local) takes effect for every load accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 64-bit mode flag; suppresses the null-use fault |
| tbl_we | input | 1 | Table-base write strobe |
| tbl_local | input | 1 | Table-base write target: 0 global, 1 local |
| tbl_base | input | ADDR_W | Table-base write data |
| ld_valid | input | 1 | Selector load request |
| ld_target | input | 3 | Register code of the load |
| ld_selector | input | 16 | Selector to load |
| ld_ready | output | 1 | Unit can accept a load |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Byte address of the descriptor entry |
| fetch_ready | input | 1 | Fetch request taken |
| resp_valid | input | 1 | Descriptor response valid |
| resp_desc | input | DESC_W | Returned descriptor |
| use_valid | input | 1 | A reference through a segment register |
| use_target | input | 3 | Register code of the reference |
| view_target | input | 3 | Register code to read out |
| view_selector | output | 16 | Selector of the read register |
| view_desc | output | DESC_W | Hidden descriptor of the read register |
| view_unusable | output | 1 | Unusable bit of the read register |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_selector | output | 16 | Selector that caused the fault |

## Verification
The bench builds the unit with its defaults: a 64-bit address width and a 64-bit descriptor width. The wide address width lets base values above bit 32 show that the index-times-8 offset is added across the full width. It also lets the top index 0x1FFF reach offset 0xFFF8 without wrap. The 64-bit descriptor width carries a distinct tag per vector, so a write into the wrong register's hidden cache shows on the read port.

// File: rtl/sel_pkg.sv
package sel_pkg;

    localparam int SEL_W   = 16;
    localparam int TGT_W   = 3;
    localparam int NUM_SEG = 7;

    typedef enum logic [TGT_W-1:0] {
        SR_CS  = 3'd0,
        SR_DS  = 3'd1,
        SR_ES  = 3'd2,
        SR_FS  = 3'd3,
        SR_GS  = 3'd4,
        SR_SS  = 3'd5,
        SR_LDT = 3'd6
    } seg_id_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } ld_state_e;

    // Registers that may hold a null selector
    function automatic logic null_allowed(input logic [TGT_W-1:0] tgt);
        return !(tgt == SR_CS || tgt == SR_SS);
    endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode
    import sel_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [SEL_W-1:0]  selector,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [ADDR_W-1:0] lbase,
    output logic              is_null,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0]  index;
    logic              local_tbl;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        index      = selector[SEL_W-1:3];
        local_tbl  = selector[2];
        is_null    = (index == '0) && !local_tbl;
        // scale by 8 regardless of descriptor width
        offset     = ADDR_W'({index, 3'b000});
        entry_addr = (local_tbl ? lbase : gbase) + offset;
    end

endmodule

// File: rtl/tbl_base_regs.sv
module tbl_base_regs #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              local_sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] gbase,
    output logic [ADDR_W-1:0] lbase
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gbase <= '0;
            lbase <= '0;
        end else if (we) begin
            if (local_sel) lbase <= wdata;
            else           gbase <= wdata;
        end
    end

endmodule

// File: rtl/seg_file.sv
module seg_file
    import sel_pkg::*;
#(
    parameter int DESC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DESC_W-1:0] wr_desc,
    input  logic              wr_unus,
    input  logic [TGT_W-1:0]  ra_idx,
    output logic [SEL_W-1:0]  ra_sel,
    output logic [DESC_W-1:0] ra_desc,
    output logic              ra_unus,
    input  logic [TGT_W-1:0]  rb_idx,
    output logic [SEL_W-1:0]  rb_sel,
    output logic              rb_unus
);
    logic [SEL_W-1:0]  sel_q  [NUM_SEG];
    logic [DESC_W-1:0] desc_q [NUM_SEG];
    logic              unus_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g]  <= '0;
                desc_q[g] <= '0;
                unus_q[g] <= 1'b1;
            end else if (wr_en && wr_idx == TGT_W'(g)) begin
                sel_q[g]  <= wr_sel;
                desc_q[g] <= wr_desc;
                unus_q[g] <= wr_unus;
            end
        end
    end

    always_comb begin
        ra_sel  = '0;
        ra_desc = '0;
        ra_unus = 1'b0;
        rb_sel  = '0;
        rb_unus = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ra_idx == TGT_W'(i)) begin
                ra_sel  = sel_q[i];
                ra_desc = desc_q[i];
                ra_unus = unus_q[i];
            end
            if (rb_idx == TGT_W'(i)) begin
                rb_sel  = sel_q[i];
                rb_unus = unus_q[i];
            end
        end
    end

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import sel_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DESC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic              tbl_we,
    input  logic              tbl_local,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              ld_valid,
    input  logic [2:0]        ld_target,
    input  logic [15:0]       ld_selector,
    output logic              ld_ready,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ready,
    input  logic              resp_valid,
    input  logic [DESC_W-1:0] resp_desc,
    input  logic              use_valid,
    input  logic [2:0]        use_target,
    input  logic [2:0]        view_target,
    output logic [15:0]       view_selector,
    output logic [DESC_W-1:0] view_desc,
    output logic              view_unusable,
    output logic              gp_fault,
    output logic [15:0]       gp_selector
);
    ld_state_e         state, state_nx;
    logic [ADDR_W-1:0] gbase, lbase, dec_addr;
    logic              dec_null;
    logic [TGT_W-1:0]  pend_tgt;
    logic [SEL_W-1:0]  pend_sel;
    logic              accept, null_ok_ld, null_bad_ld, fetch_ld;
    logic              wr_en, wr_unus;
    logic [TGT_W-1:0]  wr_idx;
    logic [SEL_W-1:0]  wr_sel, use_sel;
    logic [DESC_W-1:0] wr_desc;
    logic              use_unus, use_flt;

    tbl_base_regs #(.ADDR_W(ADDR_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .local_sel(tbl_local),
        .wdata(tbl_base), .gbase(gbase), .lbase(lbase)
    );

    sel_decode #(.ADDR_W(ADDR_W)) u_dec (
        .selector(ld_selector), .gbase(gbase), .lbase(lbase),
        .is_null(dec_null), .entry_addr(dec_addr)
    );

    seg_file #(.DESC_W(DESC_W)) u_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
        .wr_desc(wr_desc), .wr_unus(wr_unus),
        .ra_idx(view_target), .ra_sel(view_selector),
        .ra_desc(view_desc), .ra_unus(view_unusable),
        .rb_idx(use_target), .rb_sel(use_sel), .rb_unus(use_unus)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx    = state;
        ld_ready    = 1'b0;
        fetch_valid = 1'b0;
        accept      = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = ld_target;
        wr_sel      = ld_selector;
        wr_desc     = '0;
        wr_unus     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                ld_ready = 1'b1;
                accept   = ld_valid && (ld_target < TGT_W'(NUM_SEG));
                if (accept && !dec_null) state_nx = ST_ISSUE;
                wr_en    = accept && dec_null && null_allowed(ld_target);
            end
            ST_ISSUE: begin
                fetch_valid = 1'b1;
                if (fetch_ready) state_nx = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (resp_valid) begin
                    state_nx = ST_IDLE;
                    wr_en    = 1'b1;
                    wr_idx   = pend_tgt;
                    wr_sel   = pend_sel;
                    wr_desc  = resp_desc;
                    wr_unus  = 1'b0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        null_ok_ld  = accept && dec_null && null_allowed(ld_target);
        null_bad_ld = accept && dec_null && !null_allowed(ld_target);
        fetch_ld    = accept && !dec_null;
        use_flt     = use_valid && use_unus && !mode64;
    end

    // Pending load and fault capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tgt    <= '0;
            pend_sel    <= '0;
            fetch_addr  <= '0;
            gp_fault    <= 1'b0;
            gp_selector <= '0;
        end else begin
            if (fetch_ld) begin
                pend_tgt   <= ld_target;
                pend_sel   <= ld_selector;
                fetch_addr <= dec_addr;
            end
            gp_fault <= null_bad_ld || use_flt;
            if (null_bad_ld)  gp_selector <= ld_selector;
            else if (use_flt) gp_selector <= use_sel;
        end
    end

    logic unused_ok;
    assign unused_ok = null_ok_ld;

endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              ld_ready,
    input logic [2:0]        ld_target,
    input logic [15:0]       ld_selector,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              resp_valid,
    input logic              gp_fault,
    input logic [15:0]       gp_selector
);
    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

    // R2
    fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && ld_selector[15:2] != 14'd0 && ld_target != 3'd7)
        |=> (fetch_valid && !ld_ready));

    // R3
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !ld_ready);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ready && !fetch_valid && resp_valid) |=> ld_ready);

    // R5
    null_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && ld_selector[15:2] == 14'd0
         && ld_target inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6})
        |=> (!fetch_valid && ld_ready));

    // R6
    null_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && ld_selector[15:2] == 14'd0
         && (ld_target == 3'd0 || ld_target == 3'd5))
        |=> (gp_fault && gp_selector == $past(ld_selector) && !fetch_valid));

endmodule

bind seg_load_unit seg_load_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_seg_load_unit.sv
module tb_seg_load_unit;
    localparam int ADDR_W = 64;
    localparam int DESC_W = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, mode64, tbl_we, tbl_local, ld_valid, ld_ready;
    logic fetch_valid, fetch_ready, resp_valid, use_valid;
    logic view_unusable, gp_fault;
    logic [ADDR_W-1:0] tbl_base, fetch_addr;
    logic [2:0]  ld_target, use_target, view_target;
    logic [15:0] ld_selector, view_selector, gp_selector;
    logic [DESC_W-1:0] resp_desc, view_desc;

    seg_load_unit #(.ADDR_W(ADDR_W), .DESC_W(DESC_W)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_sel [7];
    logic [63:0] m_desc [7];
    logic        m_unus [7];
    logic [63:0] gb, lb;

    typedef struct packed {
        logic [2:0]  tgt;
        logic [15:0] sel;
        logic [1:0]  kind;   // 0 fetch, 1 legal null, 2 faulting null
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd1, 16'h0010, 2'd0},
        '{3'd0, 16'h0008, 2'd0},
        '{3'd5, 16'h001F, 2'd0},
        '{3'd6, 16'hFFF8, 2'd0},
        '{3'd2, 16'h0003, 2'd1},
        '{3'd0, 16'h0000, 2'd2},
        '{3'd5, 16'h0002, 2'd2},
        '{3'd6, 16'h0000, 2'd1},
        '{3'd4, 16'h0004, 2'd0},
        '{3'd3, 16'hFFFF, 2'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic view_check(input int t, input string req);
        view_target = 3'(t);
        #1;
        chk(req, 64'(view_selector), 64'(m_sel[t]));
        chk(req, view_desc, m_desc[t]);
        chk(req, 64'(view_unusable), 64'(m_unus[t]));
    endtask

    task automatic do_load(input int t, input logic [15:0] s, input int kind,
                           input logic [63:0] d);
        logic [63:0] ea;
        ea = (s[2] ? lb : gb) + {48'd0, s[15:3], 3'b000};
        ld_valid = 1'b1; ld_target = 3'(t); ld_selector = s;
        tick();
        ld_valid = 1'b0;
        if (kind == 0) begin
            chk("R3 busy after accept", 64'(ld_ready), 64'd0);
            chk("R2 fetch raised", 64'(fetch_valid), 64'd1);
            chk("R1 fetch address", fetch_addr, ea);
            fetch_ready = 1'b1;
            tick();
            fetch_ready = 1'b0;
            chk("R2 single fetch", 64'(fetch_valid), 64'd0);
            resp_valid = 1'b1; resp_desc = d;
            tick();
            resp_valid = 1'b0;
            chk("R3 ready after response", 64'(ld_ready), 64'd1);
            m_sel[t] = s; m_desc[t] = d; m_unus[t] = 1'b0;
            view_check(t, "R4 register written");
        end else if (kind == 1) begin
            chk("R5 no fetch on null", 64'(fetch_valid), 64'd0);
            chk("R5 ready stays", 64'(ld_ready), 64'd1);
            chk("R5 no fault", 64'(gp_fault), 64'd0);
            m_sel[t] = s; m_desc[t] = '0; m_unus[t] = 1'b1;
            view_check(t, "R5 null written");
        end else begin
            chk("R6 fault raised", 64'(gp_fault), 64'd1);
            chk("R6 fault selector", 64'(gp_selector), 64'(s));
            chk("R6 no fetch", 64'(fetch_valid), 64'd0);
            tick();
            chk("R6 one-cycle pulse", 64'(gp_fault), 64'd0);
            view_check(t, "R6 register unchanged");
        end
    endtask

    task automatic do_use(input int t, input logic m64, input logic exp_f,
                          input logic [15:0] exp_s);
        mode64 = m64; use_valid = 1'b1; use_target = 3'(t);
        tick();
        use_valid = 1'b0;
        chk("R7 use fault", 64'(gp_fault), 64'(exp_f));
        if (exp_f) chk("R7 use fault selector", 64'(gp_selector), 64'(exp_s));
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode64 = 1'b0; tbl_we = 1'b0; tbl_local = 1'b0; tbl_base = '0;
        ld_valid = 1'b0; ld_target = '0; ld_selector = '0; fetch_ready = 1'b0;
        resp_valid = 1'b0; resp_desc = '0; use_valid = 1'b0; use_target = '0;
        view_target = '0;
        for (int i = 0; i < 7; i++) begin
            m_sel[i] = '0; m_desc[i] = '0; m_unus[i] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk("R8 ready", 64'(ld_ready), 64'd1);
        chk("R8 no fetch", 64'(fetch_valid), 64'd0);
        chk("R8 no fault", 64'(gp_fault), 64'd0);
        for (int i = 0; i < 7; i++) view_check(i, "R8 register reset");

        // R9 table bases
        gb = 64'h0000_7FFF_0000_1000;
        lb = 64'h0000_0001_0020_0000;
        tbl_we = 1'b1; tbl_local = 1'b0; tbl_base = gb;
        tick();
        tbl_local = 1'b1; tbl_base = lb;
        tick();
        tbl_we = 1'b0;

        // vector table
        for (int i = 0; i < 10; i++)
            do_load(int'(VECS[i].tgt), VECS[i].sel, int'(VECS[i].kind),
                    64'hD00D_0000_0000_0000 | 64'(i));

        // R2 hold under backpressure, R3 load while busy ignored
        ld_valid = 1'b1; ld_target = 3'd1; ld_selector = 16'h0030;
        tick();
        ld_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R2 held without ready", 64'(fetch_valid), 64'd1);
            chk("R2 address steady", fetch_addr, gb + 64'h30);
            if (k == 1) begin
                ld_valid = 1'b1; ld_target = 3'd3; ld_selector = 16'h0000;
            end else begin
                ld_valid = 1'b0;
            end
            tick();
        end
        ld_valid = 1'b0;
        fetch_ready = 1'b1;
        tick();
        fetch_ready = 1'b0;
        resp_valid = 1'b1; resp_desc = 64'h1234_5678_9ABC_DEF0;
        tick();
        resp_valid = 1'b0;
        m_sel[1] = 16'h0030; m_desc[1] = 64'h1234_5678_9ABC_DEF0; m_unus[1] = 1'b0;
        view_check(1, "R4 register written after backpressure");
        view_check(3, "R3 busy load ignored");

        // R9 rewrite global base
        gb = 64'h0000_0000_8000_0000;
        tbl_we = 1'b1; tbl_local = 1'b0; tbl_base = gb;
        tick();
        tbl_we = 1'b0;
        do_load(2, 16'h0028, 0, 64'hAAAA_0000_0000_0028);

        // R7 use of null segment: ES null, DS usable
        do_load(2, 16'h0001, 1, 64'd0);
        do_use(2, 1'b0, 1'b1, 16'h0001);
        do_use(2, 1'b1, 1'b0, 16'h0000);
        do_use(1, 1'b0, 1'b0, 16'h0000);
        do_use(6, 1'b0, 1'b1, 16'h0000);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule